// File: doc/BRIEF.md
# Zero-Crossing Gated Dual Attenuator Wiper Controller

This block keeps the wiper settings for a two-channel logarithmic attenuator and decides when each newly written setting reaches the resistor tap. A command decoder upstream hands it an 8-bit value, a per-channel select mask and a one-cycle strobe. The strobe marks the acknowledge of the write. For every channel the block drives a tap index from 0 to 64. Indices 0 to 63 step the attenuation by 1 dB each, and 64 is the mute tap.

Zero-crossing mode is on after reset, and software can switch it off or on again. While the mode is on, a written value is only held as pending. It moves to the tap on the first zero-crossing pulse of its own channel. If no such pulse arrives, it moves when a window of CLK_HZ/20 clock cycles (50 ms) has passed since the write strobe. While the mode is off, a written value goes to the tap at once. Readback returns the last value written to each channel, and a per-channel flag shows whether that value is still pending.

Top module: `zc_wiper_ctrl`

## Requirements
- R1: After reset every channel reads back 0x3F, drives tap 63 and shows no pending update, and zero-crossing mode reads as enabled.
- R2: A register value whose bit 6 is 0 drives the tap given by bits 5:0 (0 to 63). Bit 7 has no effect on the tap.
- R3: A register value whose bit 6 is 1 drives tap 64 (mute), whatever its other bits hold.
- R4: On a write strobe, bit 0 of the select mask addresses channel 0 and bit 1 addresses channel 1. Both bits may be set together. A channel that is not addressed keeps its register, its tap and its pending state.
- R5: With zero-crossing mode off, a written value appears on the tap in the first cycle after the strobe edge, and no update is left pending.
- R6: With zero-crossing mode on, a written value is held as pending and the tap does not change. A zero-crossing pulse on that channel applies it, and the new tap shows in the cycle after the pulse edge. A pulse on the other channel does not apply it.
- R7: With zero-crossing mode on and no zero-crossing pulse, the pending value reaches the tap exactly CLK_HZ/20 clock edges after the strobe edge, and not one edge earlier.
- R8: A write to a channel that already has a pending value replaces that value and restarts that channel's window from the new strobe.
- R9: Readback of each channel returns the last value written to it, including a value that is still pending. The pending flag of a channel is 1 from the write edge until the value reaches the tap.
- R10: A zero-crossing pulse on a channel that has no pending update leaves its tap and its readback unchanged.
- R11: A mode-write strobe loads the mode-value input into the zero-crossing mode flag, and the flag shows the new value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_ack | input | 1 | One-cycle strobe at the acknowledge of a wiper write |
| wr_sel | input | NCH | Channel select mask for the write, bit i selects channel i |
| wr_data | input | 8 | New wiper register value |
| zc_en_wr | input | 1 | One-cycle strobe that writes the zero-crossing mode flag |
| zc_en_val | input | 1 | Value loaded into the mode flag |
| zc_pulse | input | NCH | Synchronized single-cycle zero-crossing pulse per channel |
| tap_o | output | NCH*7 | Decoded tap index per channel, channel i in bits 7*i+6:7*i |
| rd_o | output | NCH*8 | Register readback per channel, channel i in bits 8*i+7:8*i |
| pend_o | output | NCH | Per-channel pending-update flag |
| zc_mode_o | output | 1 | Current zero-crossing mode flag |

## Verification
Every result is registered once. Readback, the pending flag, the mode flag and a write-through tap therefore change one edge after their strobe, and a pulse-applied tap changes one edge after its pulse. A timed-out tap changes exactly CLK_HZ/20 edges after its strobe. The bench drives the inputs on the falling edge and samples in the following low phase, so each check reads the value left by the one rising edge it targets. For the window, the bench counts falling edges from the strobe and checks both the edge before the change and the edge of the change. For the restart case, it counts from the second strobe.

// File: rtl/zcw_pkg.sv
package zcw_pkg;
   localparam int CODE_W   = 8;
   localparam int TAP_W    = 7;
   localparam int MUTE_BIT = 6;
   localparam int POS_W    = 6;
   localparam logic [TAP_W-1:0]  MUTE_TAP  = TAP_W'(64);
   localparam logic [CODE_W-1:0] RESET_CODE = 8'h3F;
endpackage

// File: rtl/zcw_decode.sv
module zcw_decode
   import zcw_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   output logic [TAP_W-1:0]  tap_o
);
   always_comb begin
      if (code_i[MUTE_BIT]) tap_o = MUTE_TAP;
      else                  tap_o = TAP_W'(code_i[POS_W-1:0]);
   end
endmodule

// File: rtl/zcw_win_timer.sv
module zcw_win_timer #(
   parameter int WIN_CYC = 10_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic run_i,
   output logic expire_o
);
   localparam int CNT_W = $clog2(WIN_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   assign expire_o = run_i && !start_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (start_i)              cnt_q <= '0;
      else if (run_i && !expire_o)   cnt_q <= cnt_q + 1'b1;
   end

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/zcw_chan.sv
module zcw_chan
   import zcw_pkg::*;
#(
   parameter int WIN_CYC = 10_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_i,
   input  logic [CODE_W-1:0] data_i,
   input  logic              zc_mode_i,
   input  logic              zc_i,
   output logic [TAP_W-1:0]  tap_o,
   output logic [CODE_W-1:0] rd_o,
   output logic              pend_o
);
   logic [CODE_W-1:0] reg_q, act_q;
   logic              pend_q;
   logic              expire;

   zcw_win_timer #(.WIN_CYC(WIN_CYC)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (ld_i && zc_mode_i),
      .run_i    (pend_q),
      .expire_o (expire)
   );

   zcw_decode dec_i (
      .code_i (act_q),
      .tap_o  (tap_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q  <= RESET_CODE;
         act_q  <= RESET_CODE;
         pend_q <= 1'b0;
      end else if (ld_i) begin
         reg_q <= data_i;
         if (zc_mode_i) begin
            pend_q <= 1'b1;
         end else begin
            act_q  <= data_i;
            pend_q <= 1'b0;
         end
      end else if (pend_q && (zc_i || expire)) begin
         act_q  <= reg_q;
         pend_q <= 1'b0;
      end
   end

   assign rd_o   = reg_q;
   assign pend_o = pend_q;

   // R5
   bypass_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_i && !zc_mode_i) |=> (!pend_q && act_q == $past(data_i)));
   // R8
   reload_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_i && zc_mode_i) |=> (pend_q && reg_q == $past(data_i)));
   // R6
   zc_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && zc_i && !ld_i) |=> (!pend_q && act_q == $past(reg_q)));
   // R10
   idle_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && !ld_i) |=> $stable(act_q));
   // R3
   mute_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && reg_q[MUTE_BIT]) |-> (tap_o == MUTE_TAP));
endmodule

// File: rtl/zc_wiper_ctrl.sv
module zc_wiper_ctrl
   import zcw_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int CLK_HZ = 200_000_000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_ack,
   input  logic [NCH-1:0]        wr_sel,
   input  logic [CODE_W-1:0]     wr_data,
   input  logic                  zc_en_wr,
   input  logic                  zc_en_val,
   input  logic [NCH-1:0]        zc_pulse,
   output logic [NCH*TAP_W-1:0]  tap_o,
   output logic [NCH*CODE_W-1:0] rd_o,
   output logic [NCH-1:0]        pend_o,
   output logic                  zc_mode_o
);
   localparam int WIN_CYC = CLK_HZ / 20;

   if (NCH < 1) begin : g_bad_nch
      $error("zc_wiper_ctrl: NCH must be at least 1");
   end
   if (WIN_CYC < 2) begin : g_bad_win
      $error("zc_wiper_ctrl: CLK_HZ too small for the update window");
   end

   logic zc_mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        zc_mode_q <= 1'b1;
      else if (zc_en_wr) zc_mode_q <= zc_en_val;
   end
   assign zc_mode_o = zc_mode_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      zcw_chan #(.WIN_CYC(WIN_CYC)) chan_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .ld_i      (wr_ack && wr_sel[c]),
         .data_i    (wr_data),
         .zc_mode_i (zc_mode_q),
         .zc_i      (zc_pulse[c]),
         .tap_o     (tap_o[c*TAP_W +: TAP_W]),
         .rd_o      (rd_o[c*CODE_W +: CODE_W]),
         .pend_o    (pend_o[c])
      );
   end

   // R11
   mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zc_en_wr |=> (zc_mode_q == $past(zc_en_val)));
   // R4
   unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ack) |=> $stable(rd_o));
endmodule

// File: tb/zc_wiper_ctrl_tb_top.sv
`timescale 1ns/1ps
module zc_wiper_ctrl_tb_top;
   localparam int NCH = 2;
   localparam int CLK_HZ = 2000;
   localparam int WIN = CLK_HZ / 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_ack = 1'b0;
   logic [NCH-1:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic zc_en_wr = 1'b0;
   logic zc_en_val = 1'b0;
   logic [NCH-1:0] zc_pulse = '0;
   logic [NCH*7-1:0] tap_o;
   logic [NCH*8-1:0] rd_o;
   logic [NCH-1:0] pend_o;
   logic zc_mode_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   zc_wiper_ctrl #(.NCH(NCH), .CLK_HZ(CLK_HZ)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_ack(wr_ack), .wr_sel(wr_sel),
      .wr_data(wr_data), .zc_en_wr(zc_en_wr), .zc_en_val(zc_en_val),
      .zc_pulse(zc_pulse), .tap_o(tap_o), .rd_o(rd_o), .pend_o(pend_o),
      .zc_mode_o(zc_mode_o)
   );

   function automatic int tap(int c);
      return int'(tap_o[c*7 +: 7]);
   endfunction
   function automatic int rd(int c);
      return int'(rd_o[c*8 +: 8]);
   endfunction

   task automatic chk(string tag, int got, int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [7:0] d);
      wr_ack = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_ack = 1'b0; wr_sel = '0;
   endtask

   task automatic set_mode(logic v);
      zc_en_wr = 1'b1; zc_en_val = v;
      @(negedge clk);
      zc_en_wr = 1'b0;
   endtask

   task automatic pulse(logic [1:0] p);
      zc_pulse = p;
      @(negedge clk);
      zc_pulse = '0;
   endtask

   task automatic t_reset();
      chk("R1 tap0", tap(0), 63);
      chk("R1 tap1", tap(1), 63);
      chk("R1 rd0", rd(0), 8'h3F);
      chk("R1 pend", int'(pend_o), 0);
      chk("R1 mode", int'(zc_mode_o), 1);
   endtask

   task automatic t_direct();
      set_mode(1'b0);
      chk("R11 mode off", int'(zc_mode_o), 0);
      wr(2'b01, 8'h06);
      chk("R5 R2 tap0", tap(0), 6);
      chk("R5 pend0", int'(pend_o[0]), 0);
      chk("R4 tap1 kept", tap(1), 63);
      wr(2'b10, 8'h85);
      chk("R2 bit7 ignored tap1", tap(1), 5);
      chk("R4 tap0 kept", tap(0), 6);
      wr(2'b11, 8'h4A);
      chk("R3 R4 tap0 mute", tap(0), 64);
      chk("R3 R4 tap1 mute", tap(1), 64);
      wr(2'b01, 8'h00);
      chk("R2 tap0 zero", tap(0), 0);
   endtask

   task automatic t_zc();
      set_mode(1'b1);
      chk("R11 mode on", int'(zc_mode_o), 1);
      wr(2'b01, 8'h10);
      chk("R6 tap0 held", tap(0), 0);
      chk("R9 pend0", int'(pend_o[0]), 1);
      chk("R9 rd0 pending", rd(0), 8'h10);
      pulse(2'b10);
      chk("R10 tap1 idle pulse", tap(1), 64);
      chk("R10 rd1 idle pulse", rd(1), 8'h4A);
      chk("R6 other pulse no apply", tap(0), 0);
      pulse(2'b01);
      chk("R6 tap0 applied", tap(0), 16);
      chk("R9 pend0 cleared", int'(pend_o[0]), 0);
      wr(2'b11, 8'h20);
      pulse(2'b10);
      chk("R6 tap1 applied", tap(1), 32);
      chk("R6 tap0 still held", tap(0), 16);
      chk("R6 pend mask", int'(pend_o), 1);
      pulse(2'b01);
      chk("R6 tap0 second", tap(0), 32);
      pulse(2'b01);
      chk("R10 tap0 after applied", tap(0), 32);
   endtask

   task automatic t_timeout();
      wr(2'b01, 8'h41);
      repeat (WIN - 1) @(negedge clk);
      chk("R7 not yet", tap(0), 32);
      chk("R7 still pending", int'(pend_o[0]), 1);
      @(negedge clk);
      chk("R7 expired R3", tap(0), 64);
      chk("R7 pend cleared", int'(pend_o[0]), 0);
   endtask

   task automatic t_restart();
      wr(2'b10, 8'h0C);
      repeat (50) @(negedge clk);
      wr(2'b10, 8'h0E);
      chk("R8 rd1 replaced", rd(1), 8'h0E);
      repeat (WIN - 1) @(negedge clk);
      chk("R8 restarted window", tap(1), 32);
      @(negedge clk);
      chk("R8 new value applied", tap(1), 14);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_zc();
      t_timeout();
      t_restart();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule